// File: doc/BRIEF.md
# Password Verification and Polling Controller

This block decides whether a bus master may read or write a small protected memory. A serial bus front end feeds it start and stop strobes and one strobe per received byte. The block answers every byte with an ACK or NACK decision one clock later. A session opens with a command byte that selects read access or write access. Eight password bytes follow, and the block compares them against the stored read key or the stored write key.

Every password attempt, whether it matches or not, starts a fixed busy interval. This interval stands in for a nonvolatile write and slows down guessing. The master then sends poll bytes. While the interval runs, each poll gets NACK. Once it has ended, a poll gets ACK only if the password matched, so a wrong password cannot be told apart from a running busy interval until the full interval has passed. An accepted poll raises a grant output qualified as read or write. The grant is held until the next stop condition. The two stored keys come in from registers outside the block.

Top module: `pwd_gate_ctrl`

## Requirements
- R1: After reset, ack_valid, busy, grant_rd and grant_wr are all low.
- R2: In idle, a byte of 8'hA1 (read access) or 8'hA2 (write access) received while busy is low is answered with ACK and opens the password phase. Any other byte, or any byte received while busy is high, is answered with NACK and leaves the block idle.
- R3: ack_valid is high in exactly the cycle after each rx_valid cycle and is low otherwise. Each of the eight password bytes, sent most significant byte first, is answered with ACK.
- R4: A stop during the password phase, before the eighth byte, returns the block to idle and no busy interval starts.
- R5: In the cycle after the eighth password byte, busy goes high. It stays high for exactly BUSY_CYCLES cycles, whether or not the password matched.
- R6: A poll byte 8'h55 received while busy is high is answered with NACK, and the block stays in the poll phase. Stop and start conditions do not leave the poll phase.
- R7: A poll byte 8'h55 received after busy has dropped, following a matching password, is answered with ACK. In the same cycle, grant_rd (for a read session) or grant_wr (for a write session) goes high.
- R8: A poll byte 8'h55 received after busy has dropped, following a mismatched password, is answered with NACK, gives no grant and returns the block to idle.
- R9: Any byte other than 8'h55 received in the poll phase is answered with NACK and returns the block to idle. A busy interval that is already running continues.
- R10: A stop clears grant_rd and grant_wr in the following cycle. At most one grant is ever high. While a grant is held, further bytes are answered with ACK.
- R11: A read session is compared only against rd_key and a write session only against wr_key.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_start | input | 1 | Start condition strobe |
| bus_stop | input | 1 | Stop condition strobe |
| rx_valid | input | 1 | Received-byte strobe |
| rx_byte | input | 8 | Received byte |
| rd_key | input | 64 | Stored read password |
| wr_key | input | 64 | Stored write password |
| ack_valid | output | 1 | Decision for the previous byte is valid |
| ack | output | 1 | 1 = ACK, 0 = NACK |
| busy | output | 1 | Busy interval running |
| grant_rd | output | 1 | Read access granted |
| grant_wr | output | 1 | Write access granted |

## Verification
The assertions check on every cycle the following rules:
- a decision appears exactly one cycle after each byte;
- the busy counter loads its full length and then steps down by one;
- a poll during busy is refused;
- a stop clears the grants, and the two grants are never high together;
- an aborted password phase never starts a busy interval.

Other behaviours only the bench scenarios can show:
- the busy interval has exactly BUSY_CYCLES cycles;
- a mismatched password stays refused after the interval;
- the keys are kept separate between read and write sessions;
- a command is refused while an earlier interval is still running.

// File: rtl/pwg_pkg.sv
// Shared types and code values for the password gate controller.
// Assumes a byte-wide receive path from the bus front end.
package pwg_pkg;
    localparam int BYTE_W = 8;

    localparam logic [BYTE_W-1:0] CMD_READ  = 8'hA1;
    localparam logic [BYTE_W-1:0] CMD_WRITE = 8'hA2;
    localparam logic [BYTE_W-1:0] CMD_POLL  = 8'h55;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PWD   = 2'd1,
        ST_POLL  = 2'd2,
        ST_GRANT = 2'd3
    } ctl_state_t;

    typedef enum logic [1:0] {
        ACC_NONE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_kind_t;
endpackage

// File: rtl/pwg_shift.sv
// Collects the password bytes, most significant byte first, and flags
// the final byte. The full candidate word, with the byte being received
// as its lowest byte, is presented combinationally with that flag.
// Assumes clear and en are never high together in a meaningful way
// (clear wins).
module pwg_shift #(
    parameter int BYTE_W = 8,
    parameter int NBYTES = 8,
    localparam int WORD_W = BYTE_W * NBYTES,
    localparam int CNT_W  = $clog2(NBYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              en,
    input  logic [BYTE_W-1:0] din,
    output logic              last,
    output logic [WORD_W-1:0] word
);
    logic [WORD_W-1:0] sh_q;
    logic [CNT_W-1:0]  cnt_q;

    // Flag the byte that completes the password.
    assign last = en && (cnt_q == CNT_W'(NBYTES - 1));
    // Candidate word: the stored bytes followed by the current byte.
    assign word = {sh_q[WORD_W-BYTE_W-1:0], din};

    // Shift in bytes and count them; clear restarts the count.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            sh_q  <= '0;
            cnt_q <= '0;
        end else if (en) begin
            sh_q  <= word;
            cnt_q <= last ? '0 : cnt_q + CNT_W'(1);
        end
    end

    // R4: a cleared collector restarts from an empty count.
    a_r4_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> cnt_q == '0);
    // R3: the count never exceeds the password length.
    a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CNT_W'(NBYTES));
endmodule

// File: rtl/pwg_compare.sv
// Compares a candidate password against the key that belongs to the
// requested access kind. Purely combinational. An unknown kind never
// matches.
module pwg_compare #(
    parameter int KEY_W = 64
) (
    input  pwg_pkg::acc_kind_t kind,
    input  logic [KEY_W-1:0]   cand,
    input  logic [KEY_W-1:0]   rd_key,
    input  logic [KEY_W-1:0]   wr_key,
    output logic               match
);
    logic [KEY_W-1:0] sel_key;
    logic             kind_ok;

    // Pick the key for the session kind.
    always_comb begin
        sel_key = '0;
        kind_ok = 1'b0;
        unique case (kind)
            pwg_pkg::ACC_READ:  begin sel_key = rd_key; kind_ok = 1'b1; end
            pwg_pkg::ACC_WRITE: begin sel_key = wr_key; kind_ok = 1'b1; end
            default:            begin sel_key = '0;     kind_ok = 1'b0; end
        endcase
    end

    // Match when no bit differs.
    assign match = kind_ok && ~|(cand ^ sel_key);
endmodule

// File: rtl/pwg_busy_timer.sv
// Counts down the fixed busy interval that follows each password attempt.
// Assumes load only arrives while the counter is idle; a reload restarts
// the interval.
module pwg_busy_timer #(
    parameter int CYCLES = 2_500_000,
    localparam int CW = $clog2(CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic busy
);
    logic [CW-1:0] cnt_q;

    // Load the full length, then step down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= CW'(CYCLES);
        else if (cnt_q != '0)
            cnt_q <= cnt_q - CW'(1);
    end

    assign busy = (cnt_q != '0);

    // R5: a load starts the full interval.
    a_r5_load_full: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> cnt_q == CW'(CYCLES));
    // R5: a running interval counts down by exactly one.
    a_r5_step_down: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q != '0) |=> cnt_q == $past(cnt_q) - CW'(1));
endmodule

// File: rtl/pwd_gate_ctrl.sv
// Session controller: decodes the access command, gathers the password,
// starts the busy interval and answers polls. Access is granted only after
// a poll that follows a completed interval and a matching password.
// Assumes at most one of bus_start, bus_stop, rx_valid per cycle; if stop
// coincides with another strobe, stop wins.
module pwd_gate_ctrl #(
    parameter int PWD_BYTES   = 8,
    parameter int BUSY_CYCLES = 2_500_000,
    localparam int BYTE_W = pwg_pkg::BYTE_W,
    localparam int KEY_W  = BYTE_W * PWD_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_start,
    input  logic              bus_stop,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic [KEY_W-1:0]  rd_key,
    input  logic [KEY_W-1:0]  wr_key,
    output logic              ack_valid,
    output logic              ack,
    output logic              busy,
    output logic              grant_rd,
    output logic              grant_wr
);
    import pwg_pkg::*;

    ctl_state_t        state_q;
    acc_kind_t         kind_q;
    logic              match_q;
    logic              byte_in;
    logic              pwd_en;
    logic              pwd_clear;
    logic              pwd_last;
    logic [KEY_W-1:0]  cand;
    logic              cand_match;
    logic              timer_load;

    // A byte counts only when no stop arrives with it.
    assign byte_in    = rx_valid && !bus_stop;
    assign pwd_en     = byte_in && (state_q == ST_PWD);
    assign pwd_clear  = bus_stop || bus_start || (state_q != ST_PWD);
    assign timer_load = pwd_last;

    pwg_shift #(
        .BYTE_W (BYTE_W),
        .NBYTES (PWD_BYTES)
    ) u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (pwd_clear),
        .en    (pwd_en),
        .din   (rx_byte),
        .last  (pwd_last),
        .word  (cand)
    );

    pwg_compare #(
        .KEY_W (KEY_W)
    ) u_cmp (
        .kind   (kind_q),
        .cand   (cand),
        .rd_key (rd_key),
        .wr_key (wr_key),
        .match  (cand_match)
    );

    pwg_busy_timer #(
        .CYCLES (BUSY_CYCLES)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (timer_load),
        .busy  (busy)
    );

    // Session state, per-byte decision and grant outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            kind_q    <= ACC_NONE;
            match_q   <= 1'b0;
            ack_valid <= 1'b0;
            ack       <= 1'b0;
            grant_rd  <= 1'b0;
            grant_wr  <= 1'b0;
        end else begin
            ack_valid <= 1'b0;
            if (bus_stop) begin
                grant_rd <= 1'b0;
                grant_wr <= 1'b0;
                if (state_q != ST_POLL)
                    state_q <= ST_IDLE;
            end else if (bus_start) begin
                if (state_q == ST_PWD)
                    state_q <= ST_IDLE;
            end else if (rx_valid) begin
                ack_valid <= 1'b1;
                unique case (state_q)
                    ST_IDLE: begin
                        if (!busy && rx_byte == CMD_READ) begin
                            ack     <= 1'b1;
                            kind_q  <= ACC_READ;
                            state_q <= ST_PWD;
                        end else if (!busy && rx_byte == CMD_WRITE) begin
                            ack     <= 1'b1;
                            kind_q  <= ACC_WRITE;
                            state_q <= ST_PWD;
                        end else begin
                            ack <= 1'b0;
                        end
                    end
                    ST_PWD: begin
                        ack <= 1'b1;
                        if (pwd_last) begin
                            match_q <= cand_match;
                            state_q <= ST_POLL;
                        end
                    end
                    ST_POLL: begin
                        if (rx_byte != CMD_POLL) begin
                            ack     <= 1'b0;
                            state_q <= ST_IDLE;
                        end else if (busy) begin
                            ack <= 1'b0;
                        end else if (match_q) begin
                            ack      <= 1'b1;
                            grant_rd <= (kind_q == ACC_READ);
                            grant_wr <= (kind_q == ACC_WRITE);
                            state_q  <= ST_GRANT;
                        end else begin
                            ack     <= 1'b0;
                            state_q <= ST_IDLE;
                        end
                    end
                    ST_GRANT: ack <= 1'b1;
                    default: begin
                        ack     <= 1'b0;
                        state_q <= ST_IDLE;
                    end
                endcase
            end
        end
    end

    // R3: one decision exactly one cycle after every accepted byte.
    a_r3_ack_follows_byte: assert property (@(posedge clk) disable iff (!rst_n)
        byte_in |=> ack_valid);
    a_r3_no_spurious_ack: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_in |=> !ack_valid);
    // R6: a poll during the busy interval is refused and the phase is kept.
    a_r6_busy_poll_nack: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_POLL && byte_in && !bus_start && busy && rx_byte == CMD_POLL)
        |=> (ack_valid && !ack && state_q == ST_POLL));
    // R4: an aborted password phase never starts an interval.
    a_r4_abort_no_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PWD && bus_stop && !busy) |=> (!busy && state_q == ST_IDLE));
    // R10: a stop clears both grants, and they are never high together.
    a_r10_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
        bus_stop |=> (!grant_rd && !grant_wr));
    a_r10_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({grant_rd, grant_wr}));
    // R7: a grant only rises together with an ACK, after the interval ended.
    a_r7_grant_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(grant_rd) || $rose(grant_wr)) |-> (ack_valid && ack && !busy));
endmodule

// File: tb/tb_pwd_gate_ctrl.sv
module tb_pwd_gate_ctrl;
    localparam int BUSY = 40;
    localparam int NB   = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_start = 1'b0, bus_stop = 1'b0, rx_valid = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic [63:0] rd_key = '0, wr_key = '0;
    logic        ack_valid, ack, busy, grant_rd, grant_wr;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    pwd_gate_ctrl #(.PWD_BYTES(NB), .BUSY_CYCLES(BUSY)) dut (
        .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .bus_stop(bus_stop),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .rd_key(rd_key), .wr_key(wr_key),
        .ack_valid(ack_valid), .ack(ack), .busy(busy),
        .grant_rd(grant_rd), .grant_wr(grant_wr)
    );

    always #2 clk = ~clk;

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk); bus_start = 1'b1;
        @(negedge clk); bus_start = 1'b0;
    endtask

    task automatic pulse_stop();
        @(negedge clk); bus_stop = 1'b1;
        @(negedge clk); bus_stop = 1'b0;
    endtask

    // Send one byte; return the decision seen the cycle after.
    task automatic send(input logic [7:0] b, output logic v, output logic a);
        @(negedge clk); rx_valid = 1'b1; rx_byte = b;
        @(negedge clk); rx_valid = 1'b0;
        v = ack_valid; a = ack;
    endtask

    task automatic send_chk(input string tag, input logic [7:0] b, input logic exp_ack);
        logic v, a;
        send(b, v, a);
        check(tag, {62'd0, v, a}, {62'd0, 1'b1, exp_ack});
    endtask

    // Expected grant from the requirements: compare with the session's own key.
    function automatic logic exp_match(input bit is_wr, input logic [63:0] pw);
        return is_wr ? (pw == wr_key) : (pw == rd_key);
    endfunction

    // Command plus eight password bytes, most significant first.
    task automatic enter(input bit is_wr, input logic [63:0] pw);
        send_chk("R2 command ack", is_wr ? 8'hA2 : 8'hA1, 1'b1);
        for (int i = NB - 1; i >= 0; i--)
            send_chk("R3 password byte ack", pw[i*8 +: 8], 1'b1);
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    initial begin
        int n;
        logic v, a;
        void'($urandom(32'h5eed_1234));
        rd_key = {$urandom, $urandom};
        wr_key = {$urandom, $urandom};
        repeat (3) @(negedge clk);
        check("R1 reset ack_valid", {63'd0, ack_valid}, 0);
        check("R1 reset busy", {63'd0, busy}, 0);
        check("R1 reset grants", {62'd0, grant_rd, grant_wr}, 0);
        rst_n = 1'b1;

        // R2: an unknown command is refused.
        pulse_start();
        send_chk("R2 bad command nack", 8'h3C, 1'b0);
        pulse_stop();

        // R4: stop after five bytes aborts without a busy interval.
        pulse_start();
        send_chk("R2 read command", 8'hA1, 1'b1);
        for (int i = 0; i < 5; i++) send_chk("R3 partial byte", rd_key[(7-i)*8 +: 8], 1'b1);
        pulse_stop();
        check("R4 no busy after abort", {63'd0, busy}, 0);
        pulse_start();
        send_chk("R4 idle again accepts command", 8'hA1, 1'b1);
        pulse_stop();

        // R5, R6, R7: correct read password, busy length, early poll, grant.
        pulse_start();
        enter(1'b0, rd_key);
        check("R5 busy rises", {63'd0, busy}, 1);
        pulse_start();
        send_chk("R6 poll while busy nack", 8'h55, 1'b0);
        pulse_stop();
        send_chk("R6 poll again still busy", 8'h55, 1'b0);
        wait_idle();
        send_chk("R7 poll after busy ack", 8'h55, 1'b1);
        check("R7 read grant", {62'd0, grant_rd, grant_wr}, 2'b10);
        send_chk("R10 byte during grant ack", 8'h00, 1'b1);
        pulse_stop();
        check("R10 grant cleared by stop", {62'd0, grant_rd, grant_wr}, 0);

        // R5: exact busy length, measured on a wrong write password.
        pulse_start();
        enter(1'b1, ~wr_key);
        n = 0;
        while (busy) begin n++; @(negedge clk); end
        check("R5 busy length", n, BUSY);
        send_chk("R8 mismatch nack after busy", 8'h55, 1'b0);
        check("R8 no grant", {62'd0, grant_rd, grant_wr}, 0);
        send_chk("R8 back in idle", 8'hA2, 1'b1);
        pulse_stop();

        // R9 and R2: wrong poll byte aborts; command refused while busy.
        pulse_start();
        enter(1'b1, wr_key);
        send_chk("R9 wrong poll byte nack", 8'h56, 1'b0);
        pulse_start();
        send_chk("R2 command while busy nack", 8'hA2, 1'b0);
        wait_idle();
        send_chk("R9 poll in idle is not a command", 8'h55, 1'b0);
        check("R9 no grant after abort", {62'd0, grant_rd, grant_wr}, 0);
        pulse_stop();

        // R11: read session with the write key fails.
        pulse_start();
        enter(1'b0, wr_key);
        wait_idle();
        send_chk("R11 read with write key nack", 8'h55, exp_match(1'b0, wr_key));
        pulse_stop();

        // Random sessions against the model.
        for (int s = 0; s < 24; s++) begin
            bit is_wr = $urandom_range(0, 1) == 1;
            bit good  = $urandom_range(0, 2) != 0;
            logic [63:0] pw = is_wr ? wr_key : rd_key;
            if (!good) pw[$urandom_range(0, 63)] ^= 1'b1;
            pulse_start();
            enter(is_wr, pw);
            if ($urandom_range(0, 1) == 1) send_chk("R6 random early poll", 8'h55, 1'b0);
            wait_idle();
            send(8'h55, v, a);
            check("R7 R8 random poll", {62'd0, v, a}, {62'd0, 1'b1, exp_match(is_wr, pw)});
            check("R7 random grant", {62'd0, grant_rd, grant_wr},
                  exp_match(is_wr, pw) ? (is_wr ? 2'b01 : 2'b10) : 2'b00);
            pulse_stop();
            check("R10 random stop clears", {62'd0, grant_rd, grant_wr}, 0);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule